// File: doc/BRIEF.md
# Cell-Aligned Transmit Ingress FIFO

This block sits between a cell-layer source and a downstream cell processor. The source writes fixed-size 53-byte cells one byte per clock over an 8-bit bus, with a parity bit, a start-of-cell strobe and an active-low write enable. The block stores whole cells in a four-cell buffer. The downstream side reads them a byte at a time once a complete cell is present.

The block locks onto cell boundaries at the first start-of-cell strobe. After that it finds each later boundary by counting accepted bytes, so the source may leave the strobe low. A strobe that arrives in the middle of a cell raises a sticky error. The partly written cell is dropped, and the strobed byte becomes byte 0 of a new cell. Every stored byte has its parity checked against a selectable odd or even sense. A mismatch is flagged, but the byte is kept.

Top module: `cell_ingress_fifo`

## Requirements
- R1: Until the first accepted byte with `wr_soc` high, accepted bytes are discarded and no cell becomes available.
- R2: A byte is accepted only on a rising clock edge where `wr_en_n` is 0. With `wr_en_n` at 1, the values on `wr_data`, `wr_par` and `wr_soc` have no effect.
- R3: Once locked, every 53rd stored byte completes a cell whether or not `wr_soc` is asserted. A `wr_soc` on byte 0 of a cell is not an error.
- R4: An accepted `wr_soc` on a byte other than byte 0 sets `early_err`. The partial cell is discarded, and that byte is stored as byte 0 of a new cell in the same slot.
- R5: Parity is checked over `wr_data[7:0]` plus `wr_par`. With `par_even`=0 the total count of ones must be odd; with `par_even`=1 it must be even. A mismatch on a stored byte sets `par_err`, and the byte is still stored.
- R6: `par_err`, `early_err` and `ovf_err` stay set until `err_clr` is high at a clock edge. If a new error occurs in the same cycle as the clear, the flag stays set.
- R7: `cell_avail` is 1 exactly when at least one complete cell is stored. `rd_data` shows the current byte, and `rd_en` high at a clock edge advances to the next byte. `rd_soc` is 1 only on byte 0 of the cell being read. `rd_en` has no effect while `cell_avail` is 0.
- R8: `full` is 1 when four complete cells are stored. An accepted byte while `full` is 1 is dropped and sets `ovf_err`.
- R9: Cells are read out in the order they were completed, with their bytes in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| err_clr | input | 1 | Clears the three sticky error flags |
| wr_data | input | 8 | Write byte, bit 7 most significant |
| wr_par | input | 1 | Parity bit for `wr_data` |
| wr_soc | input | 1 | High with the first byte of a cell |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en | input | 1 | Advance to the next stored byte |
| rd_data | output | 8 | Current read byte |
| rd_soc | output | 1 | Current read byte is byte 0 of a cell |
| cell_avail | output | 1 | At least one complete cell stored |
| full | output | 1 | Four complete cells stored |
| par_err | output | 1 | Sticky parity error |
| early_err | output | 1 | Sticky early start-of-cell error |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
The assertions check a set of rules on every cycle:
- A bad-parity stored byte, an early strobe, or a write while full raises its flag on the next cycle.
- Error flags hold until cleared.
- An idle write enable leaves the byte position unchanged.
- `full` implies `cell_avail`.
- No cell appears before lock.

Only the bench scenarios can show the following:
- Data integrity and cell ordering.
- That a discarded partial cell never reaches the read side.
- That a dropped overflow byte never appears in a cell.
- That boundaries found by counting alone match what the source intended.

// File: rtl/cif_pkg.sv
package cif_pkg;
  parameter int CIF_DATA_W = 8;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } align_t;

  // 1 when the byte plus its parity bit do not match the selected sense
  function automatic logic parity_bad(input logic [CIF_DATA_W-1:0] d,
                                      input logic p,
                                      input logic even_sel);
    return ((^d) ^ p) == even_sel;
  endfunction
endpackage

// File: rtl/cif_rst_sync.sv
module cif_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cif_cell_store.sv
module cif_cell_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 212,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cif_write_ctrl.sv
module cif_write_ctrl
  import cif_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int NUM_CELLS  = 4,
  parameter int DATA_W     = CIF_DATA_W,
  localparam int BYTE_W = $clog2(CELL_BYTES),
  localparam int SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int ADDR_W = $clog2(CELL_BYTES * NUM_CELLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_even,
  input  logic              err_clr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par,
  input  logic              wr_soc,
  input  logic              wr_en_n,
  input  logic              full,
  output logic              st_we,
  output logic [ADDR_W-1:0] st_addr,
  output logic              cell_done,
  output logic              locked,
  output logic [BYTE_W-1:0] byte_idx,
  output logic              par_err,
  output logic              early_err,
  output logic              ovf_err
);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CELLS - 1);

  align_t            st_q, st_d;
  logic [BYTE_W-1:0] byte_q, byte_d, idx;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              store, restart, early_set, ovf_set, par_set;
  logic              perr_q, perr_d, eerr_q, eerr_d, oerr_q, oerr_d;

  always_comb begin
    st_d      = st_q;
    byte_d    = byte_q;
    slot_d    = slot_q;
    store     = 1'b0;
    restart   = 1'b0;
    early_set = 1'b0;
    ovf_set   = 1'b0;
    cell_done = 1'b0;
    if (!wr_en_n) begin
      if (full) begin
        ovf_set = 1'b1;
      end else if (st_q == ST_HUNT) begin
        if (wr_soc) begin
          store   = 1'b1;
          restart = 1'b1;
          st_d    = ST_LOCKED;
        end
      end else begin
        store = 1'b1;
        if (wr_soc && (byte_q != '0)) begin
          restart   = 1'b1;
          early_set = 1'b1;
        end
      end
    end
    idx = restart ? '0 : byte_q;
    if (store) begin
      if (idx == LAST_BYTE) begin
        byte_d    = '0;
        cell_done = 1'b1;
        slot_d    = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end else begin
        byte_d = idx + 1'b1;
      end
    end
    par_set = store && parity_bad(wr_data, wr_par, par_even);
    perr_d  = (perr_q & ~err_clr) | par_set;
    eerr_d  = (eerr_q & ~err_clr) | early_set;
    oerr_d  = (oerr_q & ~err_clr) | ovf_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      byte_q <= '0;
      slot_q <= '0;
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
      oerr_q <= 1'b0;
    end else begin
      if (store) begin
        st_q   <= st_d;
        byte_q <= byte_d;
        slot_q <= slot_d;
      end
      perr_q <= perr_d;
      eerr_q <= eerr_d;
      oerr_q <= oerr_d;
    end
  end

  assign st_we     = store;
  assign st_addr   = ADDR_W'(int'(slot_q) * CELL_BYTES + int'(idx));
  assign locked    = (st_q == ST_LOCKED);
  assign byte_idx  = byte_q;
  assign par_err   = perr_q;
  assign early_err = eerr_q;
  assign ovf_err   = oerr_q;
endmodule

// File: rtl/cif_read_ctrl.sv
module cif_read_ctrl #(
  parameter int CELL_BYTES = 53,
  parameter int NUM_CELLS  = 4,
  localparam int BYTE_W = $clog2(CELL_BYTES),
  localparam int SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int ADDR_W = $clog2(CELL_BYTES * NUM_CELLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              cell_avail,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cell_taken,
  output logic              rd_soc,
  output logic [BYTE_W-1:0] byte_idx
);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CELLS - 1);

  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              take;

  always_comb begin
    take       = rd_en && cell_avail;
    byte_d     = byte_q;
    slot_d     = slot_q;
    cell_taken = 1'b0;
    if (take) begin
      if (byte_q == LAST_BYTE) begin
        byte_d     = '0;
        cell_taken = 1'b1;
        slot_d     = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end else begin
        byte_d = byte_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      slot_q <= '0;
    end else if (take) begin
      byte_q <= byte_d;
      slot_q <= slot_d;
    end
  end

  assign rd_addr  = ADDR_W'(int'(slot_q) * CELL_BYTES + int'(byte_q));
  assign rd_soc   = cell_avail && (byte_q == '0);
  assign byte_idx = byte_q;
endmodule

// File: rtl/cell_ingress_fifo.sv
module cell_ingress_fifo
  import cif_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int NUM_CELLS  = 4,
  parameter int DATA_W     = CIF_DATA_W,
  localparam int BYTE_W = $clog2(CELL_BYTES),
  localparam int ADDR_W = $clog2(CELL_BYTES * NUM_CELLS),
  localparam int CNT_W  = $clog2(NUM_CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_even,
  input  logic              err_clr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par,
  input  logic              wr_soc,
  input  logic              wr_en_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_soc,
  output logic              cell_avail,
  output logic              full,
  output logic              par_err,
  output logic              early_err,
  output logic              ovf_err
);
  logic              rst_n_sync;
  logic              st_we, cell_done, cell_taken, wr_locked;
  logic [ADDR_W-1:0] st_waddr, st_raddr;
  logic [BYTE_W-1:0] wr_byte_idx, rd_byte_idx;
  logic [CNT_W-1:0]  occ_q, occ_d;
  logic              occ_en;

  cif_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  cif_write_ctrl #(.CELL_BYTES(CELL_BYTES), .NUM_CELLS(NUM_CELLS), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n_sync), .par_even(par_even), .err_clr(err_clr),
    .wr_data(wr_data), .wr_par(wr_par), .wr_soc(wr_soc), .wr_en_n(wr_en_n),
    .full(full), .st_we(st_we), .st_addr(st_waddr), .cell_done(cell_done),
    .locked(wr_locked), .byte_idx(wr_byte_idx),
    .par_err(par_err), .early_err(early_err), .ovf_err(ovf_err)
  );

  cif_read_ctrl #(.CELL_BYTES(CELL_BYTES), .NUM_CELLS(NUM_CELLS)) u_rd (
    .clk(clk), .rst_n(rst_n_sync), .rd_en(rd_en), .cell_avail(cell_avail),
    .rd_addr(st_raddr), .cell_taken(cell_taken), .rd_soc(rd_soc),
    .byte_idx(rd_byte_idx)
  );

  cif_cell_store #(.DATA_W(DATA_W), .DEPTH(CELL_BYTES * NUM_CELLS)) u_mem (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(wr_data),
    .raddr(st_raddr), .rdata(rd_data)
  );

  always_comb begin
    occ_en = cell_done ^ cell_taken;
    occ_d  = occ_q + CNT_W'(cell_done) - CNT_W'(cell_taken);
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  occ_q <= '0;
    else if (occ_en)  occ_q <= occ_d;
  end

  assign full       = (occ_q == CNT_W'(NUM_CELLS));
  assign cell_avail = (occ_q != '0);
endmodule

// File: rtl/cif_checker.sv
module cif_checker #(
  parameter int CELL_BYTES = 53,
  parameter int DATA_W     = 8,
  localparam int BYTE_W = $clog2(CELL_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              par_even,
  input logic              err_clr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_par,
  input logic              wr_soc,
  input logic              wr_en_n,
  input logic              cell_avail,
  input logic              full,
  input logic              par_err,
  input logic              early_err,
  input logic              ovf_err,
  input logic              locked,
  input logic [BYTE_W-1:0] wbyte
);
  logic stored_w;
  assign stored_w = !wr_en_n && !full && (locked || wr_soc);

  p_no_avail_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !cell_avail);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_n |=> $stable(wbyte));

  p_early_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && !full && locked && wr_soc && wbyte != '0) |=> early_err);

  p_par_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stored_w && (((^wr_data) ^ wr_par) == par_even)) |=> par_err);

  p_par_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && wr_en_n) |=> (!par_err && !early_err && !ovf_err));

  p_ovf_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && full) |=> ovf_err);

  p_full_avail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> cell_avail);
endmodule

bind cell_ingress_fifo cif_checker #(.CELL_BYTES(CELL_BYTES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .par_even(par_even), .err_clr(err_clr),
  .wr_data(wr_data), .wr_par(wr_par), .wr_soc(wr_soc), .wr_en_n(wr_en_n),
  .cell_avail(cell_avail), .full(full), .par_err(par_err),
  .early_err(early_err), .ovf_err(ovf_err), .locked(wr_locked),
  .wbyte(wr_byte_idx)
);

// File: tb/cell_ingress_fifo_bench.sv
module cell_ingress_fifo_bench;
  localparam int CB = 53;
  localparam int NC = 4;

  logic       clk, rst_n, par_even, err_clr, wr_par, wr_soc, wr_en_n, rd_en;
  logic [7:0] wr_data, rd_data;
  logic       rd_soc, cell_avail, full, par_err, early_err, ovf_err;

  int checks = 0;
  int errors = 0;

  logic [7:0] q[$];
  bit m_locked = 0;
  int m_part = 0;
  int m_cells = 0;

  cell_ingress_fifo u_cell_ingress_fifo (
    .clk(clk), .rst_n(rst_n), .par_even(par_even), .err_clr(err_clr),
    .wr_data(wr_data), .wr_par(wr_par), .wr_soc(wr_soc), .wr_en_n(wr_en_n),
    .rd_en(rd_en), .rd_data(rd_data), .rd_soc(rd_soc), .cell_avail(cell_avail),
    .full(full), .par_err(par_err), .early_err(early_err), .ovf_err(ovf_err)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] val(input int c, input int i);
    return 8'(c * 37 + i * 5 + 1);
  endfunction

  // Called at a negedge; returns at the following negedge.
  task automatic wr(input logic [7:0] d, input bit soc, input bit bad);
    wr_data = d;
    wr_soc  = soc;
    wr_par  = (^d) ^ ~par_even ^ bad;
    wr_en_n = 0;
    @(posedge clk);
    @(negedge clk);
    wr_en_n = 1;
    wr_soc  = 0;
    if (m_cells == NC) begin
    end else if (!m_locked) begin
      if (soc) begin
        m_locked = 1;
        q.push_back(d);
        m_part = 1;
      end
    end else begin
      if (soc && m_part != 0) begin
        for (int k = 0; k < m_part; k++) void'(q.pop_back());
        m_part = 0;
      end
      q.push_back(d);
      m_part++;
      if (m_part == CB) begin
        m_part = 0;
        m_cells++;
      end
    end
  endtask

  task automatic idle(input bit soc, input logic [7:0] d);
    wr_en_n = 1;
    wr_soc  = soc;
    wr_data = d;
    wr_par  = ~wr_par;
    @(posedge clk);
    @(negedge clk);
    wr_soc  = 0;
  endtask

  task automatic chk_levels(input string tag);
    chk(cell_avail == (m_cells > 0), {tag, " R7 cell_avail"}, cell_avail, m_cells > 0);
    chk(full == (m_cells == NC), {tag, " R8 full"}, full, m_cells == NC);
  endtask

  task automatic drain();
    for (int i = 0; i < CB; i++) begin
      chk(rd_data == q[0], "R9 read byte", rd_data, q[0]);
      chk(rd_soc == (i == 0), "R7 rd_soc", rd_soc, i == 0);
      rd_en = 1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 0;
      void'(q.pop_front());
    end
    m_cells--;
    chk_levels("drain");
  endtask

  initial begin
    rst_n = 0; par_even = 0; err_clr = 0; wr_data = 0; wr_par = 0;
    wr_soc = 0; wr_en_n = 1; rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    chk(cell_avail == 0 && full == 0 && rd_soc == 0, "reset R7 R8 outputs", cell_avail, 0);
    chk(par_err == 0 && early_err == 0 && ovf_err == 0, "reset R6 flags", par_err, 0);

    // R1: no start strobe yet, bytes are discarded
    for (int i = 0; i < 60; i++) wr(val(9, i), 0, 0);
    chk(cell_avail == 0, "R1 unlocked writes ignored", cell_avail, 0);

    // R2: strobes with the enable high must not lock
    for (int i = 0; i < 10; i++) idle(1, 8'hFF);
    for (int i = 0; i < CB; i++) wr(val(8, i), 0, 0);
    chk(cell_avail == 0, "R2 disabled strobe ignored", cell_avail, 0);
    chk(early_err == 0 && par_err == 0, "R2 no flags", early_err, 0);

    // R3: one strobe, then boundaries by counting
    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < CB; i++) begin
        wr(val(c, i), (c == 0 && i == 0), 0);
        if (i == 10) idle(1, 8'h55);
      end
      chk_levels("R3 counted cell");
    end
    chk(early_err == 0, "R3 no early error", early_err, 0);

    // R8: write while full
    wr(8'hEE, 0, 0);
    chk(ovf_err == 1, "R8 overflow flag", ovf_err, 1);
    chk_levels("R8 still full");

    for (int c = 0; c < NC; c++) drain();

    // R7: read enable with nothing available
    rd_en = 1;
    repeat (3) @(negedge clk);
    rd_en = 0;
    for (int i = 0; i < CB; i++) wr(val(4, i), i == 0, 0);
    chk(early_err == 0, "R3 strobe on byte 0 ok", early_err, 0);
    drain();

    // R6: clear
    err_clr = 1;
    idle(0, 0);
    err_clr = 0;
    chk(ovf_err == 0, "R6 overflow cleared", ovf_err, 0);

    // R4: early strobe discards the partial cell
    for (int i = 0; i < 20; i++) wr(val(5, i), i == 0, 0);
    for (int i = 0; i < CB; i++) wr(val(6, i), i == 0, 0);
    chk(early_err == 1, "R4 early flag", early_err, 1);
    chk(m_cells == 1, "R4 model one cell", m_cells, 1);
    chk_levels("R4 one cell");
    drain();
    chk(cell_avail == 0, "R4 partial never read", cell_avail, 0);

    // R5: exhaustive parity sweep in both senses
    for (int m = 0; m < 2; m++) begin
      par_even = m[0];
      err_clr = 1; idle(0, 0); err_clr = 0;
      for (int v = 0; v < 256; v++) begin
        wr(8'(v), 0, 0);
        chk(par_err == 0, "R5 good parity", par_err, 0);
        if (m_cells > 0) drain();
      end
      wr(8'h3C, 0, 1);
      chk(par_err == 1, "R5 bad parity flagged", par_err, 1);
      idle(0, 0);
      chk(par_err == 1, "R6 sticky", par_err, 1);
    end

    // R6: set and clear in the same cycle keeps the flag
    err_clr = 1;
    wr(8'h81, 0, 1);
    err_clr = 0;
    chk(par_err == 1, "R6 set wins over clear", par_err, 1);
    err_clr = 1; idle(0, 0); err_clr = 0;
    chk(par_err == 0, "R6 cleared", par_err, 0);

    // R5: bad-parity bytes are still stored
    while (m_part != 0) wr(8'(m_part * 3), 0, 0);
    while (m_cells > 0) drain();
    chk(cell_avail == 0, "R9 all drained", cell_avail, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule